// File: doc/BRIEF.md
# Boundary-Scan Pad Interposer

This block sits on the wires between core-side peripheral logic and a small row of IO pads. Each pad is given one of four kinds when the block is built: input only, output only, output with a tristate enable, or bidirectional. A bidirectional pad has three wires (data towards the pad, enable towards the pad, data from the pad), and the other kinds have a subset of them. The block places a pair of multiplexers on each wire that the pad kind actually has. One multiplexer faces the pad and the other faces the core.

In functional mode every wire passes straight through. In scan mode each wire is cut. The pad side is then driven from boundary-scan hold bits, and the core side is observed by, or driven from, different scan bits. Test equipment can therefore exercise a pad and a peripheral separately and tell which of the two is at fault. The capture, shift and update strobes and the serial data come from an external test access port controller, on a test clock that may run as slowly as a few kHz.

Top module: `bscan_pad_interposer`

## Requirements
- R1: While `trst_n` is low, the mode is functional, and every shift bit and every hold bit reads 0.
- R2: In functional mode, `pad_out[p]` follows `core_out[p]` for output, tristate and bidirectional pads. `pad_oe[p]` follows `core_oe[p]` for tristate and bidirectional pads. `core_in[p]` follows `pad_in[p]` for input and bidirectional pads. All of these paths are combinational.
- R3: The kind of pad p is `PAD_KINDS[2p+1:2p]`, encoded as 0 input, 1 output, 2 tristate, 3 bidirectional. Wires that a kind lacks are tied off in both modes. `pad_out` is 0 on input pads. `pad_oe` is 0 on input pads and 1 on output pads. `core_in` is 0 on output and tristate pads.
- R4: In scan mode, `pad_out`, `pad_oe` and `core_in` come only from hold bits. Changes on `core_out`, `core_oe` and `pad_in` do not reach them.
- R5: On a `tck` rising edge with `cap_en` high, each observe bit loads its wire (`core_out`, `core_oe` or `pad_in`), and each control bit keeps its value.
- R6: On a `tck` rising edge with `shift_en` high and `cap_en` low, the chain moves one place towards `tdo`. `tdi` enters the last position, and `tdo` shows position 0. Positions run pad 0 first. Within a pad the order is core-output observe, core-enable observe, pad-input observe, pad-output control, pad-enable control, core-input control, with absent wires skipped.
- R7: When `cap_en` and `shift_en` are both high, capture wins.
- R8: On a `tck` edge with `upd_en` high, every hold bit takes its shift bit from before the edge. Capture and shift never change the hold bits.
- R9: The mode register loads `scan_mode` only on an edge with `upd_en` high (1 selects scan). `scan_mode` has no effect at other times.
- R10: A low `trst_n` forces functional mode at once, without waiting for a clock edge. After `trst_n` rises, strobes are ignored on the first two `tck` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| scan_mode | input | 1 | Mode requested at the next update (1 = scan) |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain |
| core_out | input | NUM_PADS | Core data towards the pads |
| core_oe | input | NUM_PADS | Core output enables towards the pads |
| core_in | output | NUM_PADS | Data delivered to the core |
| pad_in | input | NUM_PADS | Data received from the pads |
| pad_out | output | NUM_PADS | Data driven onto the pads |
| pad_oe | output | NUM_PADS | Output enables driven onto the pads |

## Verification
The bench builds the block with four pads, one of each kind, for a chain of 14 bits. Every wire pattern, every tie-off and every within-pad ordering rule therefore appears at a known chain position. Random strobes and data in both modes reach combinations such as capture and shift together, an update during a shift, an asynchronous reset while in scan mode, and strobes during the reset release window.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    PK_IN    = 2'd0,
    PK_OUT   = 2'd1,
    PK_TRI   = 2'd2,
    PK_BIDIR = 2'd3
  } pad_kind_e;

  // kind has a core-to-pad data wire
  function automatic bit kind_drives(logic [1:0] k);
    return k != PK_IN;
  endfunction

  // kind has an output-enable wire
  function automatic bit kind_has_oe(logic [1:0] k);
    return (k == PK_TRI) || (k == PK_BIDIR);
  endfunction

  // kind has a pad-to-core data wire
  function automatic bit kind_reads(logic [1:0] k);
    return (k == PK_IN) || (k == PK_BIDIR);
  endfunction

endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/bscan_pad_cell.sv
module bscan_pad_cell
  import bscan_pkg::*;
#(
  parameter logic [1:0] KIND = 2'd3
) (
  input  logic tck,
  input  logic rst_n,
  input  logic scan_sel,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic si,
  output logic so,
  input  logic core_out_i,
  input  logic core_oe_i,
  output logic core_in_o,
  input  logic pad_in_i,
  output logic pad_out_o,
  output logic pad_oe_o
);

  localparam int HAS_DRV = kind_drives(KIND) ? 1 : 0;
  localparam int HAS_OE  = kind_has_oe(KIND) ? 1 : 0;
  localparam int HAS_RD  = kind_reads(KIND)  ? 1 : 0;
  localparam int W       = 2 * (HAS_DRV + HAS_OE + HAS_RD);
  // segment positions, position 0 nearest tdo
  localparam int I_CO  = 0;
  localparam int I_COE = I_CO  + HAS_DRV;
  localparam int I_PI  = I_COE + HAS_OE;
  localparam int I_PO  = I_PI  + HAS_RD;
  localparam int I_POE = I_PO  + HAS_DRV;
  localparam int I_CI  = I_POE + HAS_OE;

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;
  logic [W-1:0] cap_v;
  logic         unused_in;

  assign unused_in = ^{core_out_i, core_oe_i, pad_in_i};

  always_comb begin
    sh_d = sh_q;
    if (cap_en) begin
      sh_d = cap_v;
    end else if (shift_en) begin
      sh_d = {si, sh_q[W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign so = sh_q[0];

  if (HAS_DRV != 0) begin : g_drv
    logic po_hold_q;
    assign cap_v[I_CO] = core_out_i;
    assign cap_v[I_PO] = sh_q[I_PO];
    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        po_hold_q <= 1'b0;
      end else if (upd_en) begin
        po_hold_q <= sh_q[I_PO];
      end
    end
    assign pad_out_o = scan_sel ? po_hold_q : core_out_i;
  end else begin : g_no_drv
    assign pad_out_o = 1'b0;
  end

  if (HAS_OE != 0) begin : g_oe
    logic poe_hold_q;
    assign cap_v[I_COE] = core_oe_i;
    assign cap_v[I_POE] = sh_q[I_POE];
    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        poe_hold_q <= 1'b0;
      end else if (upd_en) begin
        poe_hold_q <= sh_q[I_POE];
      end
    end
    assign pad_oe_o = scan_sel ? poe_hold_q : core_oe_i;
  end else if (HAS_DRV != 0) begin : g_oe_on
    assign pad_oe_o = 1'b1;
  end else begin : g_oe_off
    assign pad_oe_o = 1'b0;
  end

  if (HAS_RD != 0) begin : g_rd
    logic ci_hold_q;
    assign cap_v[I_PI] = pad_in_i;
    assign cap_v[I_CI] = sh_q[I_CI];
    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        ci_hold_q <= 1'b0;
      end else if (upd_en) begin
        ci_hold_q <= sh_q[I_CI];
      end
    end
    assign core_in_o = scan_sel ? ci_hold_q : pad_in_i;
  end else begin : g_no_rd
    assign core_in_o = 1'b0;
  end

endmodule

// File: rtl/bscan_pad_interposer.sv
module bscan_pad_interposer #(
  parameter int                    NUM_PADS  = 4,
  parameter logic [2*NUM_PADS-1:0] PAD_KINDS = 8'b11_10_01_00
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                scan_mode,
  input  logic                cap_en,
  input  logic                shift_en,
  input  logic                upd_en,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] core_in,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);

  logic              rst_sync_n;
  logic              mode_q;
  logic              mode_d;
  logic [NUM_PADS:0] link;

  bscan_rst_sync i_rst_sync (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_sync_n)
  );

  always_comb begin
    mode_d = mode_q;
    if (upd_en) begin
      mode_d = scan_mode;
    end
  end

  always_ff @(posedge tck or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign link[NUM_PADS] = tdi;
  assign tdo            = link[0];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    bscan_pad_cell #(
      .KIND (PAD_KINDS[2*p +: 2])
    ) i_cell (
      .tck        (tck),
      .rst_n      (rst_sync_n),
      .scan_sel   (mode_q),
      .cap_en     (cap_en),
      .shift_en   (shift_en),
      .upd_en     (upd_en),
      .si         (link[p+1]),
      .so         (link[p]),
      .core_out_i (core_out[p]),
      .core_oe_i  (core_oe[p]),
      .core_in_o  (core_in[p]),
      .pad_in_i   (pad_in[p]),
      .pad_out_o  (pad_out[p]),
      .pad_oe_o   (pad_oe[p])
    );
  end

endmodule

// File: rtl/bscan_interposer_chk.sv
module bscan_interposer_chk
  import bscan_pkg::*;
#(
  parameter int                    NUM_PADS  = 4,
  parameter logic [2*NUM_PADS-1:0] PAD_KINDS = 8'b11_10_01_00
) (
  input logic                tck,
  input logic                rst_sync_n,
  input logic                mode_q,
  input logic                cap_en,
  input logic                shift_en,
  input logic                upd_en,
  input logic                tdo,
  input logic [NUM_PADS-1:0] core_out,
  input logic [NUM_PADS-1:0] core_oe,
  input logic [NUM_PADS-1:0] core_in,
  input logic [NUM_PADS-1:0] pad_in,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe
);

  logic [NUM_PADS-1:0] drv_mask;
  logic [NUM_PADS-1:0] oe_mask;
  logic [NUM_PADS-1:0] rd_mask;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_mask
    assign drv_mask[p] = kind_drives(PAD_KINDS[2*p +: 2]);
    assign oe_mask[p]  = kind_has_oe(PAD_KINDS[2*p +: 2]);
    assign rd_mask[p]  = kind_reads(PAD_KINDS[2*p +: 2]);
  end

  // R2
  passthru_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    !mode_q |-> ((pad_out & drv_mask) == (core_out & drv_mask)) &&
                ((pad_oe & oe_mask) == (core_oe & oe_mask)) &&
                ((core_in & rd_mask) == (pad_in & rd_mask)));

  // R3
  absent_wire_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    ((pad_out & ~drv_mask) == '0) && ((core_in & ~rd_mask) == '0) &&
    ((pad_oe & ~oe_mask) == (drv_mask & ~oe_mask)));

  // R4
  scan_stable_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (mode_q && $past(mode_q) && !$past(upd_en)) |->
      ($stable(pad_out) && $stable(pad_oe) && $stable(core_in)));

  // R9
  mode_hold_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    !$past(upd_en) |-> $stable(mode_q));

  // R6
  tdo_hold_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (!$past(shift_en) && !$past(cap_en)) |-> $stable(tdo));

endmodule

bind bscan_pad_interposer bscan_interposer_chk #(
  .NUM_PADS  (NUM_PADS),
  .PAD_KINDS (PAD_KINDS)
) i_chk (
  .tck        (tck),
  .rst_sync_n (rst_sync_n),
  .mode_q     (mode_q),
  .cap_en     (cap_en),
  .shift_en   (shift_en),
  .upd_en     (upd_en),
  .tdo        (tdo),
  .core_out   (core_out),
  .core_oe    (core_oe),
  .core_in    (core_in),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe)
);

// File: tb/test_bscan_pad_interposer.sv
module test_bscan_pad_interposer;

  localparam int              NP    = 4;
  localparam logic [2*NP-1:0] KINDS = 8'b11_10_01_00;
  localparam int              L     = 14;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic          trst_n, scan_mode, cap_en, shift_en, upd_en, tdi, tdo;
  logic [NP-1:0] core_out, core_oe, core_in, pad_in, pad_out, pad_oe;

  bscan_pad_interposer #(.NUM_PADS(NP), .PAD_KINDS(KINDS)) i_bscan_pad_interposer (
    .tck(tck), .trst_n(trst_n), .scan_mode(scan_mode), .cap_en(cap_en),
    .shift_en(shift_en), .upd_en(upd_en), .tdi(tdi), .tdo(tdo),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int    role_of [L];
  int    pad_of  [L];
  int    checks   = 0;
  int    errors   = 0;
  bit    finished = 0;
  string tag      = "R1";

  logic [L-1:0] m_sh, m_hold;
  logic         m_mode;
  int           rcnt;

  // roles: 0 core-out obs, 1 core-oe obs, 2 pad-in obs, 3 pad-out ctl, 4 pad-oe ctl, 5 core-in ctl
  function automatic bit has_role(int k, int r);
    if (r == 0 || r == 3) return k != 0;
    if (r == 1 || r == 4) return k >= 2;
    return (k == 0) || (k == 3);
  endfunction

  function automatic int pos(int p, int r);
    for (int i = 0; i < L; i++) if (pad_of[i] == p && role_of[i] == r) return i;
    return -1;
  endfunction

  initial begin
    int n;
    n = 0;
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < 6; r++)
        if (has_role(int'(KINDS[2*p +: 2]), r)) begin
          role_of[n] = r; pad_of[n] = p; n++;
        end
  end

  // behavioural reference: R1 R5 R6 R7 R8 R9 R10
  always @(posedge tck or negedge trst_n) begin : mdl
    logic [L-1:0] nsh;
    if (!trst_n) begin
      m_sh = '0; m_hold = '0; m_mode = 1'b0; rcnt = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      nsh = m_sh;
      if (cap_en) begin
        for (int i = 0; i < L; i++)
          case (role_of[i])
            0: nsh[i] = core_out[pad_of[i]];
            1: nsh[i] = core_oe[pad_of[i]];
            2: nsh[i] = pad_in[pad_of[i]];
            default: nsh[i] = m_sh[i];
          endcase
      end else if (shift_en) begin
        for (int i = 0; i < L-1; i++) nsh[i] = m_sh[i+1];
        nsh[L-1] = tdi;
      end
      if (upd_en) begin
        m_hold = m_sh;
        m_mode = scan_mode;
      end
      m_sh = nsh;
    end
  end

  task automatic chk(string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
    end
  endtask

  always @(negedge tck) begin : cmp
    logic [NP-1:0] e_po, e_oe, e_ci;
    for (int p = 0; p < NP; p++) begin
      int k;
      k = int'(KINDS[2*p +: 2]);
      e_po[p] = has_role(k, 0) ? (m_mode ? m_hold[pos(p, 3)] : core_out[p]) : 1'b0;
      e_oe[p] = has_role(k, 1) ? (m_mode ? m_hold[pos(p, 4)] : core_oe[p])
                               : (has_role(k, 0) ? 1'b1 : 1'b0);
      e_ci[p] = has_role(k, 2) ? (m_mode ? m_hold[pos(p, 5)] : pad_in[p]) : 1'b0;
    end
    if (!finished) begin
      chk("pad_out", pad_out, e_po);
      chk("pad_oe", pad_oe, e_oe);
      chk("core_in", core_in, e_ci);
      chk("tdo", {3'b000, tdo}, {3'b000, m_sh[0]});
    end
  end

  task automatic tick();
    @(posedge tck);
    #2;
  endtask

  task automatic rnd_data();
    core_out = NP'($urandom);
    core_oe  = NP'($urandom);
    pad_in   = NP'($urandom);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    trst_n = 1'b1; scan_mode = 1'b0; cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0;
    tdi = 1'b0; core_out = '0; core_oe = '0; pad_in = '0;
    #1 trst_n = 1'b0;
    tag = "R1 reset state";
    repeat (3) tick();
    rnd_data(); tick();
    core_oe = '0; tick();

    tag = "R10 release window";
    trst_n = 1'b1; cap_en = 1'b1; shift_en = 1'b1; upd_en = 1'b1; scan_mode = 1'b1; tdi = 1'b1;
    tick(); tick();
    cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0; scan_mode = 1'b0;
    tick();

    tag = "R2 functional passthrough";
    repeat (8) begin
      rnd_data(); scan_mode = 1'($urandom); cap_en = 1'($urandom); tick();
    end
    cap_en = 1'b0;

    tag = "R5 capture";
    core_out = 4'b1010; core_oe = 4'b1100; pad_in = 4'b1001;
    cap_en = 1'b1; tick(); cap_en = 1'b0;

    tag = "R6 shift order";
    shift_en = 1'b1;
    for (int i = 0; i < L; i++) begin
      tdi = 1'($urandom); tick();
    end
    shift_en = 1'b0; tick();

    tag = "R7 capture over shift";
    rnd_data(); cap_en = 1'b1; shift_en = 1'b1; tdi = 1'b1; tick();
    cap_en = 1'b0; tick(); shift_en = 1'b0;

    tag = "R8 update";
    shift_en = 1'b1;
    for (int i = 0; i < L; i++) begin
      tdi = 1'($urandom); tick();
    end
    shift_en = 1'b0; upd_en = 1'b1; scan_mode = 1'b1; tick(); upd_en = 1'b0; tick();

    tag = "R4 scan isolation";
    repeat (10) begin
      rnd_data(); shift_en = 1'($urandom); tdi = 1'($urandom); tick();
    end
    shift_en = 1'b0;

    tag = "R9 mode register";
    scan_mode = 1'b0; repeat (3) tick();
    upd_en = 1'b1; tick(); upd_en = 1'b0; scan_mode = 1'b1; repeat (3) begin rnd_data(); tick(); end
    upd_en = 1'b1; tick(); upd_en = 1'b0; scan_mode = 1'b0; repeat (2) begin rnd_data(); tick(); end

    tag = "R3 absent wires";
    repeat (40) begin
      rnd_data(); scan_mode = 1'($urandom); cap_en = 1'($urandom);
      shift_en = 1'($urandom); upd_en = 1'($urandom); tdi = 1'($urandom); tick();
    end
    cap_en = 1'b0; shift_en = 1'b0;

    tag = "R10 async reset in scan";
    upd_en = 1'b1; scan_mode = 1'b1; tick(); upd_en = 1'b0; rnd_data(); tick();
    trst_n = 1'b0; #1; rnd_data();
    tick(); tick();
    trst_n = 1'b1; repeat (4) begin rnd_data(); tick(); end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule